// File: doc/BRIEF.md
# Banked Byte RAM Built from Nibble Tiles

This block is a 4096-word by 8-bit random access memory made from eight small storage tiles. Each tile holds 1024 words of 4 bits. The tiles are grouped into four banks. Each bank places two tiles side by side, so one tile holds the upper nibble of every byte and the other holds the lower nibble.

The 12-bit address is split in two. The low ten bits go to every tile at once. The top two bits are decoded into a one-hot bank select. A write takes effect on the rising clock edge, and only the selected bank is written. A read is combinational: each tile that is not selected drives zero, and the banks are combined with an AND-OR multiplexer onto the output.

The array has no reset and its contents are undefined until written. The reset input only blocks writes while it is asserted.

Top module: `bank_ram`

## Requirements
- R1: When we_i=1 and rst_ni=1 at a rising edge of clk_i, the byte wdata_i is stored at addr_i. It appears on rdata_o once that edge has passed, if addr_i still points at that word.
- R2: With no write pending, rdata_o shows the byte stored at addr_i in the same cycle that addr_i changes, with no clock edge in between.
- R3: addr_i[11:10] selects exactly one of four banks, where value b picks bank b. Addresses that differ only in these bits hold independent bytes, and a write changes only the selected bank.
- R4: An edge with we_i=0 changes no stored byte. If addr_i is held, rdata_o stays stable across that edge.
- R5: In a cycle where a word is both written and read, rdata_o shows the old byte until the rising edge and the new byte after it.
- R6: While rst_ni=0, a rising edge with we_i=1 stores nothing. Reads during reset still return the stored byte.
- R7: Bits 7:4 and 3:0 of each byte are kept in separate tiles. Both nibbles are written together and come back unchanged for any value of either one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes happen on its rising edge |
| rst_ni | input | 1 | Active-low reset; blocks writes while low |
| we_i | input | 1 | Write enable |
| addr_i | input | 12 | Byte address; bits 11:10 pick the bank, bits 9:0 pick the word |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |

## Verification
The two operations that can share a cycle are a write and a combinational read of the same word.

The bench provokes this in a directed case, and also lets random traffic hit it by chance. The random traffic reuses a small pool of addresses, so the read address often matches the word being written.

Before each edge, rdata_o is compared with the old byte held in the bench's model. The model is updated only after the edge, and the next cycle's read must then return the new byte.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;
  parameter int unsigned TILE_AW   = 10;
  parameter int unsigned TILE_DW   = 4;
  parameter int unsigned BANK_BITS = 2;
  parameter int unsigned SLICES    = 2;
endpackage

// File: rtl/bank_sel_dec.sv
module bank_sel_dec #(
  parameter int unsigned BANK_BITS = 2,
  localparam int unsigned NB = 1 << BANK_BITS
) (
  input  logic [BANK_BITS-1:0] bank_i,
  input  logic                 wr_en_i,
  output logic [NB-1:0]        rd_sel_o,
  output logic [NB-1:0]        wr_sel_o
);
  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign rd_sel_o[b] = (bank_i == BANK_BITS'(b));
    assign wr_sel_o[b] = rd_sel_o[b] & wr_en_i;
  end
endmodule

// File: rtl/nib_tile.sv
module nib_tile #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (cs_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  // deselected tile drives zero so banks can be OR-combined
  assign rdata_o = cs_i ? mem_q[addr_i] : '0;
endmodule

// File: rtl/bank_pair.sv
module bank_pair #(
  parameter int unsigned AW     = 10,
  parameter int unsigned TDW    = 4,
  parameter int unsigned SLICES = 2,
  localparam int unsigned DW = TDW * SLICES
) (
  input  logic          clk_i,
  input  logic          rd_sel_i,
  input  logic          wr_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    nib_tile #(.AW(AW), .DW(TDW)) u_tile (
      .clk_i  (clk_i),
      .cs_i   (rd_sel_i),
      .we_i   (wr_sel_i),
      .addr_i (addr_i),
      .wdata_i(wdata_i[s*TDW +: TDW]),
      .rdata_o(rdata_o[s*TDW +: TDW])
    );
  end
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int unsigned TILE_AW   = bank_ram_pkg::TILE_AW,
  parameter int unsigned TILE_DW   = bank_ram_pkg::TILE_DW,
  parameter int unsigned BANK_BITS = bank_ram_pkg::BANK_BITS,
  parameter int unsigned SLICES    = bank_ram_pkg::SLICES,
  localparam int unsigned ADDR_W    = TILE_AW + BANK_BITS,
  localparam int unsigned DATA_W    = TILE_DW * SLICES,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_BANKS-1:0] rd_bank_sel;
  logic [NUM_BANKS-1:0] wr_bank_sel;
  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

  bank_sel_dec #(.BANK_BITS(BANK_BITS)) u_dec (
    .bank_i  (addr_i[ADDR_W-1:TILE_AW]),
    .wr_en_i (we_i & rst_ni),
    .rd_sel_o(rd_bank_sel),
    .wr_sel_o(wr_bank_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_pair #(.AW(TILE_AW), .TDW(TILE_DW), .SLICES(SLICES)) u_bank (
      .clk_i   (clk_i),
      .rd_sel_i(rd_bank_sel[b]),
      .wr_sel_i(wr_bank_sel[b]),
      .addr_i  (addr_i[TILE_AW-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (bank_rdata[b])
    );
  end

  // AND-OR read mux: unselected banks already drive zero
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata_o |= bank_rdata[b];
  end
endmodule

// File: rtl/bank_ram_chk.sv
module bank_ram_chk #(
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [NB-1:0] rd_sel,
  input logic [NB-1:0] wr_sel
);
  p_rd_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_sel) == 1);

  p_wr_onehot0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel) && (we_i || wr_sel == '0));

  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i)));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !$stable(addr_i) || $stable(rdata_o));
endmodule

bind bank_ram bank_ram_chk #(.NB(NUM_BANKS), .AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .rd_sel (rd_bank_sel),
  .wr_sel (wr_bank_sel)
);

// File: tb/bank_ram_test.sv
`timescale 1ns/1ps
module bank_ram_test;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk_i = ~clk_i;

  bank_ram uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [DW-1:0] fill_pat(int a);
    return DW'((a * 37) ^ (a >> 4) ^ 8'h5a);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, addr_i, act, exp);
    end
  endtask

  // drive at negedge, check read before the edge, update model after it
  task automatic op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string req);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d;
    #1 check(req, rdata_o, model[a]);
    @(posedge clk_i);
    if (we && rst_ni) model[a] = d;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h1b2c));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // initialize every word
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk_i);
      we_i = 1'b1; addr_i = AW'(a); wdata_i = fill_pat(a);
      @(posedge clk_i);
      model[a] = fill_pat(a);
    end

    // R2: combinational read follows address without an edge
    @(negedge clk_i);
    we_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      addr_i = AW'(i * 683 + 11);
      #0.3 check("R2", rdata_o, model[i * 683 + 11]);
    end

    // R3: same low address in every bank, distinct values
    for (int b = 0; b < 4; b++) op(1'b1, {2'(b), 10'h155}, DW'(8'h10 + b), "R3");
    for (int b = 0; b < 4; b++) op(1'b0, {2'(b), 10'h155}, 8'h00, "R3");
    // R3: writing bank 2 left neighbours untouched
    op(1'b1, {2'd2, 10'h3ff}, 8'hc3, "R3");
    op(1'b0, {2'd1, 10'h3ff}, 8'h00, "R3");
    op(1'b0, {2'd3, 10'h3ff}, 8'h00, "R3");
    op(1'b0, {2'd2, 10'h3ff}, 8'h00, "R3");

    // R4: edges with we_i=0 change nothing, output stable
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 12'h0a0; wdata_i = 8'hff;
    repeat (3) begin
      @(negedge clk_i);
      check("R4", rdata_o, model[12'h0a0]);
    end

    // R5: read during write shows old then new
    op(1'b1, 12'h800, 8'h99, "R5");
    op(1'b0, 12'h800, 8'h00, "R5");

    // R7: nibble independence at the bank edges
    op(1'b1, 12'h000, 8'hf0, "R7");
    op(1'b1, 12'hfff, 8'h0f, "R7");
    op(1'b0, 12'h000, 8'h00, "R7");
    op(1'b0, 12'hfff, 8'h00, "R7");
    op(1'b1, 12'h000, 8'ha5, "R7");
    op(1'b0, 12'h000, 8'h00, "R7");

    // R6: write attempt during reset is dropped, read still works
    @(negedge clk_i);
    rst_ni = 1'b0; we_i = 1'b1; addr_i = 12'h456; wdata_i = ~model[12'h456];
    #1 check("R6", rdata_o, model[12'h456]);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
    check("R6", rdata_o, model[12'h456]);
    rst_ni = 1'b1;
    op(1'b0, 12'h456, 8'h00, "R6");

    // R1 random traffic on a small address pool to force collisions
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = {2'($urandom_range(0, 3)), 10'($urandom_range(0, 7)) + 10'h200};
      op(1'($urandom_range(0, 1)), a, 8'($urandom), "R1");
    end
    for (int a = 12'h200; a < 12'h208; a++)
      for (int b = 0; b < 4; b++) op(1'b0, {2'(b), a[9:0]}, 8'h00, "R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule